// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes host commands for a byte-wide nonvolatile memory that is erased in whole blocks, and it sequences the resulting byte programs and block erases. A host drives an SRAM-style bus: active-low chip enable, output enable and write enable, plus a 20-bit address and byte data. Underneath, the array appears only as a handshake port. The controller raises a program or erase request and holds it until the array answers with a one-cycle done pulse, which may carry a fail flag. Host reads are combinational. Depending on the current read mode, a read returns array bytes, the status byte or an identifier byte.

A host write is taken when write enable rises while chip enable is low. Address and data are latched at that moment. The sequencer has six states. IDLE decodes single-write commands. PGM_SETUP and ERS_SETUP wait for the second write of a two-write sequence. PGM_BUSY and ERS_BUSY hold a request to the array. ERS_HELD is a suspended erase. The transitions are:

- IDLE→PGM_SETUP on 0x40.
- IDLE→ERS_SETUP on 0x20.
- PGM_SETUP→PGM_BUSY on any data write with the supply good, or →IDLE with the supply low.
- ERS_SETUP→ERS_BUSY on 0xD0 with the supply good, or →IDLE otherwise.
- PGM_BUSY→IDLE and ERS_BUSY→IDLE on array done.
- ERS_BUSY→ERS_HELD on 0xB0.
- ERS_HELD→ERS_BUSY on 0xD0.
- Any state→IDLE while powerdown is asserted.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, or after powerdown is released, reads return array data (read-array mode) and the status byte is 0x80.
- R2: Writing 0x40 and then a second write issues a byte program: `arr_prog_req` stays high with the second write's address and data on `arr_op_addr`/`arr_op_data` until `arr_done`.
- R3: Writing 0x20 and then 0xD0 issues an erase of the block given by address bits 19:16 of the confirm write. Any second byte other than 0xD0 starts no erase and sets status bit 5.
- R4: `ry_by` is low only in PGM_BUSY or ERS_BUSY with powerdown released. It is high when idle, when an erase is suspended, and at once when `pwd_n` goes low.
- R5: `ry_by` does not depend on `ce_n` or `oe_n`.
- R6: While `pwd_n` is low, the sequencer returns to IDLE, all status error bits clear, array requests drop and host writes are ignored.
- R7: For WAKE_CYC cycles after `pwd_n` rises, host writes are ignored.
- R8: Writing 0xB0 during an erase drops `arr_erase_req` and sets status bit 6 with bit 7 high. During the suspension, array reads from the erasing block return 0xFF and other blocks read normally. Writing 0xD0 resumes the erase.
- R9: With `vpp_ok` low, a program or erase issues no array request and leaves the array unchanged. A program sets status bits 4 and 3; an erase sets bits 5 and 3.
- R10: A done pulse with `arr_fail` set sets status bit 4 after a program, or bit 5 after an erase.
- R11: Status error bits 5:3 stay set across other commands until 0x50 is written in IDLE.
- R12: In IDLE, 0xFF selects array reads, 0x70 selects status reads, and 0x90 selects identifier reads (address bit 0 = 0 gives MFR_ID, 1 gives DEV_ID). A setup write, or finishing a two-write sequence, selects status reads. `dout` is 0 and `dout_oe` is low unless `ce_n` and `oe_n` are low with powerdown released.
- R13: Command bytes with no meaning in the current state are ignored. During PGM_BUSY every host write is ignored.
- R14: Address and data are taken as they stand at the rising edge of `we_n`. Values present at the falling edge are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwd_n | input | 1 | Active-low deep powerdown |
| vpp_ok | input | 1 | Programming supply valid |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 20 | Host address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (0 when not enabled) |
| dout_oe | output | 1 | Read data valid / drive enable |
| ry_by | output | 1 | High = ready, low = program or erase running |
| arr_rd_addr | output | 20 | Array read address |
| arr_rd_data | input | 8 | Array read data |
| arr_prog_req | output | 1 | Byte program request, held until done |
| arr_erase_req | output | 1 | Block erase request, held until done |
| arr_op_addr | output | 20 | Address of the program or erase |
| arr_op_data | output | 8 | Byte to program |
| arr_done | input | 1 | One-cycle completion pulse |
| arr_fail | input | 1 | Completion failed, valid with done |

## Verification
The bench targets a suspend while the erase is running, and a design that kept the erase request up or lost its place in the erase would either finish the erase early or never finish it. It checks that reads of the block under erase are masked during the suspension, which a design without the block comparison would fail by returning stale array bytes. Error bits are checked across unrelated commands and across powerdown: a design that cleared them on the wrong command would lose an error, and one that did not clear them on powerdown would show old errors after wake-up. Writes issued inside the wake interval, writes issued while busy, and a data byte that changes between the falling and rising edge of write enable expose a design that decodes too early or latches on the wrong edge.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int DATA_W = 8;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] OP_READ_IDENT  = 8'h90;
    localparam logic [7:0] OP_PGM_SETUP   = 8'h40;
    localparam logic [7:0] OP_ERS_SETUP   = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;

    localparam int SB_READY   = 7;
    localparam int SB_SUSP    = 6;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_PGM_ERR = 4;
    localparam int SB_SUPPLY  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_ERS_HELD
    } seq_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2
    } rd_mode_t;
endpackage

// File: rtl/fcc_wr_capture.sv
module fcc_wr_capture
    import fcc_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int WAKE_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int WCW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC + 1) : 1;
    localparam logic [WCW-1:0] WAKE_LOAD = WCW'(WAKE_CYC);

    logic           we_q;
    logic [WCW-1:0] wake_cnt;
    logic           we_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            wake_cnt <= '0;
        end else begin
            we_q <= we_n;
            if (!pwd_n)
                wake_cnt <= WAKE_LOAD;
            else if (wake_cnt != '0)
                wake_cnt <= wake_cnt - 1'b1;
        end
    end

    always_comb begin
        we_rise = !we_q && we_n && !ce_n;
        wr_stb  = we_rise && pwd_n && (wake_cnt == '0);
        wr_addr = addr;
        wr_data = din;
    end

    AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((WAKE_CYC > 0) && !$past(pwd_n)) |-> !wr_stb); // R7
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BLK_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              vpp_ok,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arr_done,
    input  logic              arr_fail,
    output rd_mode_t          rd_mode,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              prog_req,
    output logic              erase_req,
    output logic              busy,
    output logic              held
);
    seq_state_t state, state_nx;
    logic err_ers, err_pgm, err_vpp;
    logic [2:0] err_bits;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !pwd_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_stb && wr_data == OP_PGM_SETUP)      state_nx = ST_PGM_SETUP;
                else if (wr_stb && wr_data == OP_ERS_SETUP) state_nx = ST_ERS_SETUP;
            end
            ST_PGM_SETUP: begin
                if (wr_stb) state_nx = vpp_ok ? ST_PGM_BUSY : ST_IDLE;
            end
            ST_ERS_SETUP: begin
                if (wr_stb)
                    state_nx = (wr_data == OP_CONFIRM && vpp_ok) ? ST_ERS_BUSY : ST_IDLE;
            end
            ST_PGM_BUSY: begin
                if (arr_done) state_nx = ST_IDLE;
            end
            ST_ERS_BUSY: begin
                if (arr_done)                                state_nx = ST_IDLE;
                else if (wr_stb && wr_data == OP_SUSPEND)    state_nx = ST_ERS_HELD;
            end
            ST_ERS_HELD: begin
                if (wr_stb && wr_data == OP_CONFIRM) state_nx = ST_ERS_BUSY;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // mode, sticky errors and operation latch
    always_ff @(posedge clk) begin
        if (!rst_n || !pwd_n) begin
            rd_mode <= RD_ARRAY;
            err_ers <= 1'b0;
            err_pgm <= 1'b0;
            err_vpp <= 1'b0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            if (wr_stb) begin
                unique case (state)
                    ST_IDLE: begin
                        case (wr_data)
                            OP_READ_ARRAY:  rd_mode <= RD_ARRAY;
                            OP_READ_STATUS: rd_mode <= RD_STATUS;
                            OP_READ_IDENT:  rd_mode <= RD_IDENT;
                            OP_PGM_SETUP:   rd_mode <= RD_STATUS;
                            OP_ERS_SETUP:   rd_mode <= RD_STATUS;
                            OP_CLEAR_STAT: begin
                                err_ers <= 1'b0;
                                err_pgm <= 1'b0;
                                err_vpp <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                    ST_PGM_SETUP: begin
                        rd_mode <= RD_STATUS;
                        if (vpp_ok) begin
                            op_addr <= wr_addr;
                            op_data <= wr_data;
                        end else begin
                            err_pgm <= 1'b1;
                            err_vpp <= 1'b1;
                        end
                    end
                    ST_ERS_SETUP: begin
                        rd_mode <= RD_STATUS;
                        if (wr_data != OP_CONFIRM) begin
                            err_ers <= 1'b1;
                        end else if (vpp_ok) begin
                            op_addr <= wr_addr;
                        end else begin
                            err_ers <= 1'b1;
                            err_vpp <= 1'b1;
                        end
                    end
                    ST_ERS_HELD: begin
                        if (wr_data == OP_READ_ARRAY)
                            rd_mode <= RD_ARRAY;
                        else if (wr_data == OP_READ_STATUS || wr_data == OP_CONFIRM)
                            rd_mode <= RD_STATUS;
                    end
                    default: ;
                endcase
            end
            if (state == ST_PGM_BUSY && arr_done && arr_fail) err_pgm <= 1'b1;
            if (state == ST_ERS_BUSY && arr_done && arr_fail) err_ers <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        prog_req  = (state == ST_PGM_BUSY);
        erase_req = (state == ST_ERS_BUSY);
        busy      = prog_req || erase_req;
        held      = (state == ST_ERS_HELD);
        err_bits  = {err_ers, err_pgm, err_vpp};
        status    = {!busy, held, err_bits, 3'b000};
    end

    AST_PWD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwd_n |=> (state == ST_IDLE && err_bits == 3'b000)); // R6
    AST_SUSPEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && state == ST_ERS_BUSY && wr_stb && wr_data == OP_SUSPEND && !arr_done)
        |=> (!erase_req && status[SB_SUSP] && status[SB_READY])); // R8
    AST_SUPPLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && state == ST_PGM_SETUP && wr_stb && !vpp_ok)
        |=> (!prog_req && status[SB_PGM_ERR] && status[SB_SUPPLY])); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && !(wr_stb && state == ST_IDLE && wr_data == OP_CLEAR_STAT))
        |=> ((err_bits & $past(err_bits)) == $past(err_bits))); // R11
endmodule

// File: rtl/fcc_read_mux.sv
module fcc_read_mux
    import fcc_pkg::*;
#(
    parameter int          BLK_W  = 4,
    parameter logic [7:0]  MFR_ID = 8'h5A,
    parameter logic [7:0]  DEV_ID = 8'hC3
) (
    input  logic              pwd_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  rd_mode_t          rd_mode,
    input  logic [BLK_W-1:0]  rd_blk,
    input  logic              rd_lsb,
    input  logic [BLK_W-1:0]  held_blk,
    input  logic              held,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (rd_mode)
            RD_STATUS: sel = status;
            RD_IDENT:  sel = rd_lsb ? DEV_ID : MFR_ID;
            default:   sel = (held && rd_blk == held_blk) ? 8'hFF : arr_rd_data;
        endcase
        dout_oe = pwd_n && !ce_n && !oe_n;
        dout    = dout_oe ? sel : '0;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         BLK_W    = 4,
    parameter int         WAKE_CYC = 125,
    parameter logic [7:0] MFR_ID   = 8'h5A,
    parameter logic [7:0] DEV_ID   = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwd_n,
    input  logic              vpp_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              ry_by,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [7:0]        arr_rd_data,
    output logic              arr_prog_req,
    output logic              arr_erase_req,
    output logic [ADDR_W-1:0] arr_op_addr,
    output logic [7:0]        arr_op_data,
    input  logic              arr_done,
    input  logic              arr_fail
);
    localparam int BLK_LSB = ADDR_W - BLK_W;

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    rd_mode_t          rd_mode;
    logic [7:0]        status;
    logic              busy, held;

    fcc_wr_capture #(.ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC)) u_cap (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .din(din),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fcc_seq #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .vpp_ok(vpp_ok),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_done(arr_done), .arr_fail(arr_fail),
        .rd_mode(rd_mode), .status(status),
        .op_addr(arr_op_addr), .op_data(arr_op_data),
        .prog_req(arr_prog_req), .erase_req(arr_erase_req),
        .busy(busy), .held(held)
    );

    fcc_read_mux #(.BLK_W(BLK_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .pwd_n(pwd_n), .ce_n(ce_n), .oe_n(oe_n), .rd_mode(rd_mode),
        .rd_blk(addr[ADDR_W-1:BLK_LSB]), .rd_lsb(addr[0]),
        .held_blk(arr_op_addr[ADDR_W-1:BLK_LSB]), .held(held),
        .status(status), .arr_rd_data(arr_rd_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    assign ry_by       = !pwd_n || !busy;
    assign arr_rd_addr = addr;

    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_n && (arr_prog_req || arr_erase_req)) |-> !ry_by); // R4
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({arr_prog_req, arr_erase_req}) <= 1); // R2
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    localparam int WAKE = 20;
    localparam int LAT  = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, pwd_n, vpp_ok, ce_n, oe_n, we_n;
    logic [19:0] addr;
    logic [7:0]  din, dout, arr_rd_data, arr_op_data;
    logic        dout_oe, ry_by, arr_prog_req, arr_erase_req;
    logic [19:0] arr_rd_addr, arr_op_addr;
    logic        arr_done = 1'b0, arr_fail = 1'b0;

    flash_cmd_ctrl #(.WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .vpp_ok(vpp_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .ry_by(ry_by),
        .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_prog_req(arr_prog_req), .arr_erase_req(arr_erase_req),
        .arr_op_addr(arr_op_addr), .arr_op_data(arr_op_data),
        .arr_done(arr_done), .arr_fail(arr_fail)
    );

    int total = 0, bad = 0;
    bit run = 0;
    bit fail_next = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // array model
    logic [7:0] mem [int];
    int mem_ver = 0;
    int rcnt = 0;

    function automatic logic [7:0] rd_mem(input logic [19:0] a);
        int k = int'(a);
        if (mem.exists(k)) return mem[k];
        return 8'hFF;
    endfunction

    task automatic erase_blk(input int b);
        int doomed[$];
        foreach (mem[k]) if ((k >> 16) == b) doomed.push_back(k);
        foreach (doomed[i]) mem.delete(doomed[i]);
    endtask

    always @(arr_rd_addr or mem_ver) arr_rd_data = rd_mem(arr_rd_addr);

    always @(negedge clk) begin
        arr_done = 1'b0;
        arr_fail = 1'b0;
        if (!rst_n || !pwd_n) rcnt = 0;
        else if (arr_prog_req || arr_erase_req) begin
            rcnt++;
            if (rcnt == LAT) begin
                rcnt = 0;
                arr_done = 1'b1;
                arr_fail = fail_next;
                if (!fail_next) begin
                    if (arr_prog_req) mem[int'(arr_op_addr)] = arr_op_data;
                    else erase_blk(int'(arr_op_addr[19:16]));
                    mem_ver++;
                end
            end
        end
    end

    // reference model: 0 idle, 1 pgm setup, 2 ers setup, 3 pgm busy, 4 ers busy, 5 held
    int m_state = 0, m_mode = 0, m_wake = 0;
    logic m_weq = 1'b1;
    logic [2:0] m_err = 3'b0;
    logic [19:0] m_opaddr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_wake = 0; m_weq = 1'b1; m_err = 3'b0; m_opaddr = '0;
        end else begin
            automatic bit stb = !m_weq && we_n && !ce_n && pwd_n && (m_wake == 0);
            automatic int old = m_state;
            m_weq = we_n;
            if (!pwd_n) begin
                m_wake = WAKE; m_state = 0; m_mode = 0; m_err = 3'b0; m_opaddr = '0;
            end else begin
                if (m_wake > 0) m_wake--;
                if (stb) begin
                    if (old == 0) begin
                        if (din == 8'hFF) m_mode = 0;
                        else if (din == 8'h70) m_mode = 1;
                        else if (din == 8'h90) m_mode = 2;
                        else if (din == 8'h50) m_err = 3'b0;
                        else if (din == 8'h40) begin m_state = 1; m_mode = 1; end
                        else if (din == 8'h20) begin m_state = 2; m_mode = 1; end
                    end else if (old == 1) begin
                        m_mode = 1;
                        if (vpp_ok) begin m_opaddr = addr; m_state = 3; end
                        else begin m_err |= 3'b011; m_state = 0; end
                    end else if (old == 2) begin
                        m_mode = 1;
                        m_state = 0;
                        if (din != 8'hD0) m_err |= 3'b100;
                        else if (!vpp_ok) m_err |= 3'b101;
                        else begin m_opaddr = addr; m_state = 4; end
                    end else if (old == 4) begin
                        if (din == 8'hB0) m_state = 5;
                    end else if (old == 5) begin
                        if (din == 8'hFF) m_mode = 0;
                        else if (din == 8'h70) m_mode = 1;
                        else if (din == 8'hD0) begin m_mode = 1; m_state = 4; end
                    end
                end
                if (old == 3 && arr_done) begin m_state = 0; if (arr_fail) m_err |= 3'b010; end
                if (old == 4 && arr_done) begin m_state = 0; if (arr_fail) m_err |= 3'b100; end
            end
        end
    end

    function automatic logic [7:0] exp_dout();
        automatic bit busy = (m_state == 3 || m_state == 4);
        if (!(pwd_n && !ce_n && !oe_n)) return 8'h00;
        if (m_mode == 1) return {!busy, m_state == 5, m_err, 3'b000};
        if (m_mode == 2) return addr[0] ? 8'hC3 : 8'h5A;
        if (m_state == 5 && addr[19:16] == m_opaddr[19:16]) return 8'hFF;
        return rd_mem(addr);
    endfunction

    always @(posedge clk) begin
        #3;
        if (rst_n && run) begin
            automatic bit busy = (m_state == 3 || m_state == 4);
            chk("R4 ry_by per cycle", ry_by, !pwd_n || !busy);
            chk("R2 prog_req per cycle", arr_prog_req, m_state == 3);
            chk("R3 erase_req per cycle", arr_erase_req, m_state == 4);
            chk("R12 dout per cycle", dout, exp_dout());
            if (busy) chk("R2 op_addr per cycle", arr_op_addr, m_opaddr);
        end
    end

    // host tasks
    task automatic host_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 0; addr = a; din = d; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic host_write_split(input logic [19:0] a, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk); ce_n = 0; addr = a; din = d0; we_n = 0;
        @(negedge clk); din = d1;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic host_read(input logic [19:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
        #1 d = dout;
        #1 ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!ry_by) @(negedge clk);
    endtask

    task automatic do_prog(input logic [19:0] a, input logic [7:0] d);
        host_write(a, 8'h40);
        host_write(a, d);
        wait_ready();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 0; pwd_n = 1; vpp_ok = 1; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0;
        repeat (4) @(negedge clk);
        rst_n = 1; run = 1;
        @(negedge clk);

        host_read(20'h12345, rd); chk("R1 array after reset", rd, 8'hFF);
        host_write(0, 8'h70); host_read(0, rd); chk("R1 status after reset", rd, 8'h80);
        #1 chk("R4 ry idle", ry_by, 1);

        host_write(0, 8'h90);
        host_read(20'h0, rd); chk("R12 ident mfr", rd, 8'h5A);
        host_read(20'h1, rd); chk("R12 ident dev", rd, 8'hC3);
        @(negedge clk); ce_n = 0; oe_n = 1;
        #1 chk("R12 gated dout", dout, 0); chk("R12 gated oe", dout_oe, 0);
        ce_n = 1;

        host_write(0, 8'h70); host_write(0, 8'h33);
        host_read(0, rd); chk("R13 unknown ignored", rd, 8'h80);

        host_write(20'h21003, 8'h40); host_write(20'h21003, 8'h3C);
        #1 chk("R2 prog req", arr_prog_req, 1);
        chk("R2 op addr", arr_op_addr, 20'h21003);
        chk("R2 op data", arr_op_data, 8'h3C);
        chk("R4 ry busy", ry_by, 0);
        host_write(0, 8'hFF);
        wait_ready();
        host_read(0, rd); chk("R13 busy write ignored", rd, 8'h80);
        host_write(0, 8'hFF); host_read(20'h21003, rd); chk("R2 programmed", rd, 8'h3C);

        host_write(20'h00010, 8'h40); host_write_split(20'h00010, 8'h11, 8'h77);
        #1 chk("R14 rising capture", arr_op_data, 8'h77);
        wait_ready();
        host_write(0, 8'hFF); host_read(20'h00010, rd); chk("R14 stored byte", rd, 8'h77);

        do_prog(20'h30005, 8'hAA);
        do_prog(20'h50001, 8'h55);
        host_write(20'h3ABCD, 8'h20); host_write(20'h3ABCD, 8'hD0);
        #1 chk("R3 erase req", arr_erase_req, 1);
        chk("R3 erase block", arr_op_addr[19:16], 4'h3);
        wait_ready();
        host_write(0, 8'hFF);
        host_read(20'h30005, rd); chk("R3 block erased", rd, 8'hFF);
        host_read(20'h50001, rd); chk("R3 other block kept", rd, 8'h55);

        host_write(20'h50000, 8'h20); host_write(20'h50000, 8'hD0);
        @(negedge clk); ce_n = 1; oe_n = 1;
        #1 chk("R5 ry low while deselected", ry_by, 0);
        host_write(0, 8'hB0);
        #1 chk("R8 erase paused", arr_erase_req, 0);
        chk("R4 ry suspended", ry_by, 1);
        host_read(0, rd); chk("R8 suspend status", rd, 8'hC0);
        host_write(0, 8'hFF);
        host_read(20'h50001, rd); chk("R8 held block masked", rd, 8'hFF);
        host_read(20'h21003, rd); chk("R8 other block readable", rd, 8'h3C);
        repeat (20) @(negedge clk);
        #1 chk("R8 stays paused", arr_erase_req, 0);
        host_write(0, 8'hD0);
        #1 chk("R8 resumed", arr_erase_req, 1);
        wait_ready();
        host_read(0, rd); chk("R8 status after resume", rd, 8'h80);
        host_write(0, 8'hFF); host_read(20'h50001, rd); chk("R8 erase finished", rd, 8'hFF);

        host_write(0, 8'h20); host_write(0, 8'h33);
        #1 chk("R3 no erase on bad confirm", arr_erase_req, 0);
        host_read(0, rd); chk("R3 sequence error", rd, 8'hA0);
        host_write(0, 8'hFF); host_write(0, 8'h70);
        host_read(0, rd); chk("R11 error sticky", rd, 8'hA0);
        host_write(0, 8'h50); host_read(0, rd); chk("R11 cleared", rd, 8'h80);

        vpp_ok = 0;
        host_write(20'h60000, 8'h40); host_write(20'h60000, 8'h12);
        #1 chk("R9 no program", arr_prog_req, 0);
        host_read(0, rd); chk("R9 program lockout status", rd, 8'h98);
        host_write(0, 8'h50);
        host_write(20'h60000, 8'h20); host_write(20'h60000, 8'hD0);
        #1 chk("R9 no erase", arr_erase_req, 0);
        host_read(0, rd); chk("R9 erase lockout status", rd, 8'hA8);
        host_write(0, 8'h50); vpp_ok = 1;
        host_write(0, 8'hFF); host_read(20'h60000, rd); chk("R9 array unaltered", rd, 8'hFF);

        fail_next = 1;
        do_prog(20'h70000, 8'hAB);
        host_read(0, rd); chk("R10 program fail", rd, 8'h90);
        host_write(0, 8'h50);
        host_write(20'h21000, 8'h20); host_write(20'h21000, 8'hD0);
        wait_ready();
        host_read(0, rd); chk("R10 erase fail", rd, 8'hA0);
        host_write(0, 8'h50); fail_next = 0;
        host_write(0, 8'hFF);
        host_read(20'h21003, rd); chk("R10 failed erase kept data", rd, 8'h3C);

        host_write(0, 8'h20); host_write(0, 8'h33);
        host_write(20'h20000, 8'h20); host_write(20'h20000, 8'hD0);
        #1 chk("R4 ry before powerdown", ry_by, 0);
        pwd_n = 0;
        #1 chk("R6 ry in powerdown", ry_by, 1);
        @(negedge clk); @(negedge clk);
        #1 chk("R6 request dropped", arr_erase_req, 0);
        host_write(0, 8'h40);
        #1 chk("R6 write ignored in powerdown", arr_prog_req, 0);
        @(negedge clk); pwd_n = 1;
        host_write(0, 8'h70);
        host_read(20'h21003, rd); chk("R7 write in wake ignored", rd, 8'h3C);
        chk("R1 array mode after wake", rd, 8'h3C);
        repeat (WAKE + 2) @(negedge clk);
        host_write(0, 8'h70);
        host_read(0, rd); chk("R6 status cleared", rd, 8'h80);

        run = 0;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule